// File: doc/BRIEF.md
# Reserved-Region Bus Abort Decoder

This block watches every bus access and tells the core when the address lands somewhere it must not go. Each access arrives as a one-cycle strobe with a 32-bit address and a bit that marks it as an instruction fetch or a data access. The block sorts the address into a region of a memory map and raises a prefetch abort for a bad fetch or a data abort for a bad data access. Both flags are registered. Two parameters set the size of the non-volatile memory and of the SRAM, and these sizes move the edges of the reserved gaps that follow each memory. Two bit masks list the peripheral windows that exist.

Fetches carry their verdict forward. Each fetched word enters a two-entry tag queue together with its abort bit. The abort reaches the core only when an execute request pops that word. A flush empties the queue, so a prefetch that runs past the end of memory and is never executed causes no abort. Inside an existing peripheral window only the window itself is decoded, so an undefined offset there does not abort.

Top module: `abt_guard`

## Requirements
- R1: With memory of NVM_KB kilobytes, addresses 0 to NVM_KB*1024-1 are legal and addresses from NVM_KB*1024 to 0x3FFF_FFFF abort for both fetch and data.
- R2: With SRAM of SRAM_KB kilobytes, 0x4000_0000 up to 0x4000_0000+SRAM_KB*1024-1 is legal, the rest up to 0x7FFF_CFFF aborts for both kinds, and 0x7FFF_D000 to 0x7FFF_FFFF is legal for both.
- R3: Every address from 0x8000_0000 to 0xDFFF_FFFF aborts for both fetch and data.
- R4: Every fetch from 0xE000_0000 or above gives a prefetch abort, whether the peripheral window exists or not.
- R5: Two ranges hold peripheral windows. 0xE000_0000 to 0xE01F_FFFF has 128 windows of 16 kB, indexed by address bits [20:14] into APB_MASK. 0xFFE0_0000 to 0xFFFF_FFFF has 8 windows of 256 kB, indexed by bits [20:18] into AHB_MASK. A data access at any offset inside a window whose mask bit is 1 does not abort; for example 0xE000_D000 behaves like 0xE000_C000.
- R6: A data access above 0xDFFF_FFFF aborts when its window's mask bit is 0. It also aborts when the address lies outside both window ranges.
- R7: pf_abort and dt_abort are due in the cycle after the strobe edge. They are both 0 when the strobe was low. pf_abort is only set for a fetch and dt_abort only for a data access.
- R8: A valid fetch pushes {fetch_word, abort bit} into the queue, and a data access pushes nothing. An execute request on a non-empty queue pops the oldest entry, and one cycle later exec_valid is 1 with that entry's word and bit on exec_word and exec_abort. With an empty queue, exec_valid stays 0.
- R9: flush empties the queue (q_level becomes 0) and forces exec_valid and exec_abort to 0 on the next cycle. A push or pop in the same cycle as the flush is ignored.
- R10: A push into a full queue is dropped unless a pop happens in the same cycle. q_level never exceeds 2.
- R11: A bad fetch raises exec_abort only in the cycle after the execute request that pops it. If the entry is flushed before it is executed, it never raises exec_abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe |
| acc_is_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| acc_addr | input | 32 | Access address |
| fetch_word | input | 32 | Fetched word that travels with a fetch |
| exec_req | input | 1 | Pop the oldest queued word for execution |
| flush | input | 1 | Discard every queued word |
| pf_abort | output | 1 | Registered prefetch abort of the last access |
| dt_abort | output | 1 | Registered data abort of the last access |
| exec_valid | output | 1 | A word was popped last cycle |
| exec_word | output | 32 | Popped word |
| exec_abort | output | 1 | Abort taken with the popped word |
| q_level | output | LVL_W | Queue occupancy |

## Verification
Every result of this block is due exactly one clock edge after the input that causes it. The access flags follow the strobe edge. exec_valid, exec_word and exec_abort follow the execute or flush edge, and q_level follows any push, pop or flush. The driver applies one set of inputs per cycle on the falling edge and queues the values expected after the next rising edge. The monitor samples 2 ns after each rising edge and pops exactly one expectation. This keeps every comparison aligned to that single registered stage. Three instances with different memory sizes receive the same addresses, so the moving boundaries are checked side by side.

// File: rtl/abt_pkg.sv
package abt_pkg;

    localparam logic [31:0] SRAM_BASE = 32'h4000_0000;
    localparam logic [31:0] BOOT_BASE = 32'h7FFF_D000;
    localparam logic [31:0] HOLE_BASE = 32'h8000_0000;
    localparam logic [31:0] APB_BASE  = 32'hE000_0000;
    localparam logic [31:0] AHB_BASE  = 32'hF000_0000;

    localparam int APB_SLOT_W = 7;           // 16 kB windows, bits [20:14]
    localparam int AHB_SLOT_W = 3;           // 256 kB windows, bits [20:18]
    localparam logic [10:0] APB_TOP = 11'h700;  // addr[31:21] of decoded peripheral bus range
    localparam logic [10:0] AHB_TOP = 11'h7FF;  // addr[31:21] of decoded fast peripheral range

    typedef enum logic [3:0] {
        RG_NVM, RG_GAP_NVM, RG_SRAM, RG_GAP_SRAM, RG_BOOT,
        RG_GAP_HIGH, RG_APB_OK, RG_APB_HOLE, RG_AHB_OK, RG_AHB_HOLE
    } region_e;

    typedef struct packed {
        logic fetch_bad;
        logic data_bad;
    } verdict_t;

    typedef struct packed {
        logic [31:0] word;
        logic        flag;
    } tag_entry_t;

    function automatic verdict_t judge(region_e r);
        verdict_t v;
        unique case (r)
            RG_NVM, RG_SRAM, RG_BOOT: v = '{fetch_bad: 1'b0, data_bad: 1'b0};
            RG_APB_OK, RG_AHB_OK:     v = '{fetch_bad: 1'b1, data_bad: 1'b0};
            default:                  v = '{fetch_bad: 1'b1, data_bad: 1'b1};
        endcase
        return v;
    endfunction

endpackage

// File: rtl/abt_region_dec.sv
module abt_region_dec
    import abt_pkg::*;
#(
    parameter int unsigned NVM_KB  = 512,
    parameter int unsigned SRAM_KB = 32,
    parameter logic [2**APB_SLOT_W-1:0] APB_MASK = 128'h8000_0000_0000_0000_0000_0000_0000_1BFF,
    parameter logic [2**AHB_SLOT_W-1:0] AHB_MASK = 8'h80
) (
    input  logic [31:0] addr,
    output region_e     region,
    output verdict_t    verdict
);
    localparam logic [31:0] NVM_END  = 32'(NVM_KB * 1024);
    localparam logic [31:0] SRAM_END = SRAM_BASE + 32'(SRAM_KB * 1024);

    always_comb begin
        if (addr < NVM_END)                region = RG_NVM;
        else if (addr < SRAM_BASE)         region = RG_GAP_NVM;
        else if (addr < SRAM_END)          region = RG_SRAM;
        else if (addr < BOOT_BASE)         region = RG_GAP_SRAM;
        else if (addr < HOLE_BASE)         region = RG_BOOT;
        else if (addr < APB_BASE)          region = RG_GAP_HIGH;
        else if (addr < AHB_BASE)
            region = (addr[31:21] == APB_TOP && APB_MASK[addr[20:14]]) ? RG_APB_OK : RG_APB_HOLE;
        else
            region = (addr[31:21] == AHB_TOP && AHB_MASK[addr[20:18]]) ? RG_AHB_OK : RG_AHB_HOLE;
        verdict = judge(region);
    end
endmodule

// File: rtl/abt_flag_stage.sv
module abt_flag_stage
    import abt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     valid,
    input  logic     is_fetch,
    input  verdict_t verdict,
    output logic     pf_abort,
    output logic     dt_abort
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pf_abort <= 1'b0;
            dt_abort <= 1'b0;
        end else begin
            pf_abort <= valid &  is_fetch & verdict.fetch_bad;
            dt_abort <= valid & ~is_fetch & verdict.data_bad;
        end
    end

    a_r7_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
        !valid |=> (!pf_abort && !dt_abort));
    a_r7_one_kind: assert property (@(posedge clk) disable iff (rst)
        !(pf_abort && dt_abort));
    a_r7_data_no_pf: assert property (@(posedge clk) disable iff (rst)
        (valid && !is_fetch) |=> !pf_abort);
endmodule

// File: rtl/abt_fetch_tag.sv
module abt_fetch_tag
    import abt_pkg::*;
#(
    parameter int DEPTH = 2,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  tag_entry_t       push_entry,
    input  logic             pop_req,
    input  logic             flush,
    output logic             out_valid,
    output logic [31:0]      out_word,
    output logic             out_abort,
    output logic [CNT_W-1:0] level
);
    tag_entry_t       mem   [DEPTH];
    tag_entry_t       shifted [DEPTH];
    tag_entry_t       mem_n [DEPTH];
    logic [CNT_W-1:0] count, count_n;
    logic             do_pop, do_push;
    int               base;

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_shift
            if (g < DEPTH - 1) begin : g_mid
                assign shifted[g] = mem[g + 1];
            end else begin : g_last
                assign shifted[g] = '0;
            end
        end
    endgenerate

    always_comb begin
        do_pop  = pop_req && (count != '0);
        base    = int'(count) - (do_pop ? 1 : 0);
        do_push = push && (base < DEPTH);
        for (int i = 0; i < DEPTH; i++)
            mem_n[i] = do_pop ? shifted[i] : mem[i];
        if (do_push)
            mem_n[base] = push_entry;
        count_n = CNT_W'(base + (do_push ? 1 : 0));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count     <= '0;
            out_valid <= 1'b0;
            out_abort <= 1'b0;
            out_word  <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (flush) begin
            count     <= '0;
            out_valid <= 1'b0;
            out_abort <= 1'b0;
        end else begin
            count     <= count_n;
            out_valid <= do_pop;
            out_abort <= do_pop & mem[0].flag;
            if (do_pop) out_word <= mem[0].word;
            for (int i = 0; i < DEPTH; i++) mem[i] <= mem_n[i];
        end
    end

    assign level = count;

    a_r9_flush_clears: assert property (@(posedge clk) disable iff (rst)
        flush |=> (count == '0 && !out_valid && !out_abort));
    a_r10_no_overflow: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));
    a_r11_abort_needs_pop: assert property (@(posedge clk) disable iff (rst)
        out_abort |-> out_valid);
    a_r8_empty_pop_idle: assert property (@(posedge clk) disable iff (rst)
        (pop_req && count == '0 && !flush) |=> !out_valid);
endmodule

// File: rtl/abt_guard.sv
module abt_guard
    import abt_pkg::*;
#(
    parameter int unsigned NVM_KB  = 512,
    parameter int unsigned SRAM_KB = 32,
    parameter logic [2**APB_SLOT_W-1:0] APB_MASK = 128'h8000_0000_0000_0000_0000_0000_0000_1BFF,
    parameter logic [2**AHB_SLOT_W-1:0] AHB_MASK = 8'h80,
    parameter int QDEPTH = 2,
    parameter int LVL_W  = $clog2(QDEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_valid,
    input  logic             acc_is_fetch,
    input  logic [31:0]      acc_addr,
    input  logic [31:0]      fetch_word,
    input  logic             exec_req,
    input  logic             flush,
    output logic             pf_abort,
    output logic             dt_abort,
    output logic             exec_valid,
    output logic [31:0]      exec_word,
    output logic             exec_abort,
    output logic [LVL_W-1:0] q_level
);
    region_e    region;
    verdict_t   verdict;
    tag_entry_t entry;

    abt_region_dec #(
        .NVM_KB(NVM_KB), .SRAM_KB(SRAM_KB), .APB_MASK(APB_MASK), .AHB_MASK(AHB_MASK)
    ) u_dec (
        .addr(acc_addr), .region(region), .verdict(verdict)
    );

    abt_flag_stage u_flags (
        .clk(clk), .rst(rst), .valid(acc_valid), .is_fetch(acc_is_fetch),
        .verdict(verdict), .pf_abort(pf_abort), .dt_abort(dt_abort)
    );

    assign entry = '{word: fetch_word, flag: verdict.fetch_bad};

    abt_fetch_tag #(.DEPTH(QDEPTH), .CNT_W(LVL_W)) u_tag (
        .clk(clk), .rst(rst), .push(acc_valid & acc_is_fetch), .push_entry(entry),
        .pop_req(exec_req), .flush(flush), .out_valid(exec_valid), .out_word(exec_word),
        .out_abort(exec_abort), .level(q_level)
    );

    a_r3_high_gap: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_addr >= 32'h8000_0000 && acc_addr <= 32'hDFFF_FFFF)
            |=> (pf_abort || dt_abort));
    a_r4_periph_fetch: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_is_fetch && acc_addr[31:29] == 3'b111) |=> pf_abort);
endmodule

// File: tb/abt_guard_tb.sv
module abt_guard_tb;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [2:0]  pf, dt;
        logic        ev, ea;
        logic [31:0] ew;
        logic [1:0]  lvl;
        int          atag, qtag;
    } item_t;

    logic clk = 1'b0, rst = 1'b1;
    logic v = 0, f = 0, ex = 0, fl = 0;
    logic [31:0] a = '0, w = '0;
    logic [2:0] pf, dt;
    logic ev0, ea0; logic [31:0] ew0; logic [1:0] lv0;
    logic ev1, ea1; logic [31:0] ew1; logic [1:0] lv1;
    logic ev2, ea2; logic [31:0] ew2; logic [1:0] lv2;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    item_t sb[$];
    logic [31:0] mq_w[$];
    logic        mq_f[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    abt_guard #(.NVM_KB(512), .SRAM_KB(32)) u_dut (
        .clk(clk), .rst(rst), .acc_valid(v), .acc_is_fetch(f), .acc_addr(a), .fetch_word(w),
        .exec_req(ex), .flush(fl), .pf_abort(pf[0]), .dt_abort(dt[0]), .exec_valid(ev0),
        .exec_word(ew0), .exec_abort(ea0), .q_level(lv0));
    abt_guard #(.NVM_KB(32), .SRAM_KB(8)) u_dut_s (
        .clk(clk), .rst(rst), .acc_valid(v), .acc_is_fetch(f), .acc_addr(a), .fetch_word(w),
        .exec_req(ex), .flush(fl), .pf_abort(pf[1]), .dt_abort(dt[1]), .exec_valid(ev1),
        .exec_word(ew1), .exec_abort(ea1), .q_level(lv1));
    abt_guard #(.NVM_KB(128), .SRAM_KB(16)) u_dut_m (
        .clk(clk), .rst(rst), .acc_valid(v), .acc_is_fetch(f), .acc_addr(a), .fetch_word(w),
        .exec_req(ex), .flush(fl), .pf_abort(pf[2]), .dt_abort(dt[2]), .exec_valid(ev2),
        .exec_word(ew2), .exec_abort(ea2), .q_level(lv2));

    function automatic string req_name(int t);
        case (t)
            1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
            5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
            9: return "R9";  10: return "R10"; default: return "R11";
        endcase
    endfunction

    // reference verdict {fetch_bad, data_bad} for a given memory size
    function automatic logic [1:0] ref_bad(logic [31:0] ad, int nk, int sk);
        longint unsigned x = longint'(ad);
        int slot;
        if (x < longint'(nk) * 1024)                   return 2'b00;
        if (x < 64'h4000_0000)                          return 2'b11;
        if (x < 64'h4000_0000 + longint'(sk) * 1024)    return 2'b00;
        if (x <= 64'h7FFF_CFFF)                         return 2'b11;
        if (x <= 64'h7FFF_FFFF)                         return 2'b00;
        if (x <= 64'hDFFF_FFFF)                         return 2'b11;
        if (x <= 64'hE01F_FFFF) begin
            slot = int'((x - 64'hE000_0000) >> 14);
            return {1'b1, !((slot <= 9) || slot == 11 || slot == 12 || slot == 127)};
        end
        if (x < 64'hFFE0_0000)                          return 2'b11;
        slot = int'((x - 64'hFFE0_0000) >> 18);
        return {1'b1, slot != 7};
    endfunction

    function automatic int atag_of(logic [31:0] ad, logic fe);
        logic [1:0] r;
        if (ad < 32'h4000_0000) return 1;
        if (ad < 32'h8000_0000) return 2;
        if (ad < 32'hE000_0000) return 3;
        if (fe) return 4;
        r = ref_bad(ad, 512, 32);
        return r[0] ? 6 : 5;
    endfunction

    task automatic step(logic sv, logic sf, logic [31:0] sa, logic [31:0] sw,
                        logic sex, logic sfl, int at, int qt);
        item_t it;
        logic [1:0] r;
        bit pop;
        @(negedge clk);
        v = sv; f = sf; a = sa; w = sw; ex = sex; fl = sfl;
        for (int k = 0; k < 3; k++) begin
            r = ref_bad(sa, (k == 0) ? 512 : (k == 1) ? 32 : 128, (k == 0) ? 32 : (k == 1) ? 8 : 16);
            it.pf[k] = sv & sf & r[1];
            it.dt[k] = sv & ~sf & r[0];
        end
        it.ew = '0;
        if (sfl) begin
            mq_w.delete(); mq_f.delete();
            it.ev = 0; it.ea = 0;
        end else begin
            pop = sex && mq_w.size() > 0;
            it.ev = pop; it.ea = 0;
            if (pop) begin
                it.ew = mq_w.pop_front();
                it.ea = mq_f.pop_front();
            end
            if (sv && sf && mq_w.size() < 2) begin
                r = ref_bad(sa, 512, 32);
                mq_w.push_back(sw); mq_f.push_back(r[1]);
            end
        end
        it.lvl = 2'(mq_w.size());
        it.atag = at; it.qtag = qt;
        sb.push_back(it);
    endtask

    task automatic acc(logic sf, logic [31:0] sa, int qt);
        step(1, sf, sa, sa ^ 32'h5A5A_0000, 0, 0, atag_of(sa, sf), qt);
    endtask

    task automatic chk(int t, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req_name(t), what, act, exp);
        end
    endtask

    // monitor: one expectation per cycle, sampled after the rising edge
    initial begin
        item_t it;
        forever begin
            @(posedge clk); #2;
            if (!rst && sb.size() > 0) begin
                it = sb.pop_front();
                chk(it.atag, "pf_abort[512k]", 32'(pf[0]), 32'(it.pf[0]));
                chk(it.atag, "dt_abort[512k]", 32'(dt[0]), 32'(it.dt[0]));
                chk(it.atag, "pf_abort[32k]",  32'(pf[1]), 32'(it.pf[1]));
                chk(it.atag, "dt_abort[32k]",  32'(dt[1]), 32'(it.dt[1]));
                chk(it.atag, "pf_abort[128k]", 32'(pf[2]), 32'(it.pf[2]));
                chk(it.atag, "dt_abort[128k]", 32'(dt[2]), 32'(it.dt[2]));
                chk(it.qtag, "exec_valid", 32'(ev0), 32'(it.ev));
                chk(it.qtag, "exec_abort", 32'(ea0), 32'(it.ea));
                chk(it.qtag, "q_level",    32'(lv0), 32'(it.lvl));
                if (it.ev) chk(it.qtag, "exec_word", ew0, it.ew);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] pts[$];
        int nks[3] = '{32, 128, 512};
        int sks[3] = '{8, 16, 32};
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk); #1;
        // reset state (R7, R8)
        chk(7, "pf after reset", 32'(pf), 0);
        chk(7, "dt after reset", 32'(dt), 0);
        chk(8, "exec_valid after reset", 32'(ev0), 0);
        chk(8, "q_level after reset", 32'(lv0), 0);

        // boundary sweep over every size, both access kinds
        for (int c = 0; c < 3; c++) begin
            pts.delete();
            pts.push_back(32'h0);
            pts.push_back(32'(nks[c] * 1024) - 1);
            pts.push_back(32'(nks[c] * 1024));
            pts.push_back(32'h3FFF_FFFF);
            pts.push_back(32'h4000_0000);
            pts.push_back(32'h4000_0000 + 32'(sks[c] * 1024) - 1);
            pts.push_back(32'h4000_0000 + 32'(sks[c] * 1024));
            pts.push_back(32'h7FFF_CFFF);
            pts.push_back(32'h7FFF_D000);
            pts.push_back(32'h7FFF_FFFF);
            pts.push_back(32'h8000_0000);
            pts.push_back(32'hDFFF_FFFF);
            pts.push_back(32'hE000_0000);
            pts.push_back(32'hE000_C000);
            pts.push_back(32'hE000_D000);
            pts.push_back(32'hE002_8000);
            pts.push_back(32'hE002_BFFF);
            pts.push_back(32'hE01F_C000);
            pts.push_back(32'hE020_0000);
            pts.push_back(32'hEFFF_FFFF);
            pts.push_back(32'hF000_0000);
            pts.push_back(32'hFFDF_FFFF);
            pts.push_back(32'hFFE0_0000);
            pts.push_back(32'hFFFB_FFFF);
            pts.push_back(32'hFFFC_0000);
            pts.push_back(32'hFFFF_FFFF);
            step(0, 0, 0, 0, 0, 1, 7, 9);
            foreach (pts[i]) begin
                acc(1'b1, pts[i], 10);
                acc(1'b0, pts[i], 10);
            end
        end

        // strobe low on a reserved address: no flags (R7)
        step(0, 1, 32'h9000_0000, 0, 0, 1, 7, 9);
        step(0, 0, 32'h9000_0000, 0, 0, 0, 7, 8);
        step(0, 1, 32'hE000_0000, 0, 0, 0, 7, 8);

        // ordered pop of good then bad fetch (R8, R11)
        step(1, 1, 32'h0000_0100, 32'hAAAA_0001, 0, 0, 1, 8);
        step(1, 1, 32'h9000_0000, 32'hBBBB_0002, 0, 0, 3, 8);
        step(1, 0, 32'h4000_0010, 0, 0, 0, 2, 8);     // data access: no push
        step(0, 0, 0, 0, 0, 0, 7, 11);                // bad entry waits, no abort yet
        step(0, 0, 0, 0, 1, 0, 7, 8);
        step(0, 0, 0, 0, 1, 0, 7, 11);
        step(0, 0, 0, 0, 1, 0, 7, 8);                 // pop on empty

        // bad fetch flushed before execute never aborts (R9, R11)
        step(1, 1, 32'h0010_0000, 32'hCCCC_0003, 0, 0, 1, 11);
        step(0, 0, 0, 0, 0, 1, 7, 9);
        step(0, 0, 0, 0, 1, 0, 7, 11);

        // flush beats push and pop in the same cycle (R9)
        step(1, 1, 32'h0000_0200, 32'hDDDD_0004, 0, 0, 1, 8);
        step(1, 1, 32'hE000_4000, 32'hDDDD_0005, 1, 1, 4, 9);
        step(0, 0, 0, 0, 1, 0, 7, 9);

        // full queue drops, push with pop when full accepted (R10)
        step(1, 1, 32'h0000_0300, 32'hEEEE_0001, 0, 0, 1, 10);
        step(1, 1, 32'hF000_0000, 32'hEEEE_0002, 0, 0, 4, 10);
        step(1, 1, 32'h0000_0304, 32'hEEEE_0003, 0, 0, 1, 10);
        step(1, 1, 32'hA000_0000, 32'hEEEE_0004, 1, 0, 3, 10);
        step(0, 0, 0, 0, 1, 0, 7, 10);
        step(0, 0, 0, 0, 1, 0, 7, 11);
        step(0, 0, 0, 0, 1, 0, 7, 10);
        step(0, 0, 0, 0, 0, 0, 7, 8);

        wait (sb.size() == 0);
        @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule